// File: doc/BRIEF.md
# Counted FIFO Burst Transfer Controller

This block sits between a host data path and a 512-entry sample FIFO and tracks long block transfers. Software writes a transfer length, sets the enable bits and then writes to a write-only arm location. From then on, every sample that enters or leaves the FIFO is counted down. A status word reports when the count reaches zero, when the FIFO is at least half full, and whether a write into a full FIFO or a read from an empty FIFO has happened.

The down-counter is wider than the FIFO address. One armed transfer can therefore move many times the FIFO depth, with the FIFO refilled and drained as it goes. The overrun and underrun flags are gated by their own enable bit. Software that moves less than one FIFO per transfer can leave them silent. Each flag stays set until software reads the status word or arms again.

Top module: `burst_fifo_ctrl`

## Requirements
- R1: After synchronous active-low reset, the control word reads 0, the remaining count reads 0, and the status word reads 0x0010 (only the empty bit set).
- R2: The FIFO holds 512 samples in order. `pop_data` always shows the oldest sample. `fifo_full` is high at 512 entries and `fifo_empty` is high at 0 entries.
- R3: A push into a full FIFO stores nothing, and a pop from an empty FIFO removes nothing. The FIFO contents and order are unchanged afterwards.
- R4: Any write to address 2 (arm) loads the remaining count from the length register and sets the armed bit (status bit 6). The written data has no effect, and reading address 2 returns 0.
- R5: While the block is armed and enabled, each accepted push and each accepted pop lowers the remaining count by one. The count is read at address 3 and stays at zero until the next arm.
- R6: Status bit 0 (done) is 1 when the enable bit is set, the block is armed and the remaining count is zero.
- R7: Status bit 1 is 1 when the enable bit is set and the FIFO holds at least 256 samples.
- R8: Status bit 2 (overrun: push while full) and status bit 3 (underrun: pop while empty) are set only if the error-enable bit is 1 in that cycle. Once set, they stay set.
- R9: A status read (address 1) clears both error flags, but a new error in the same cycle wins. An arm write clears both error flags, and the arm wins over a same-cycle error.
- R10: The count is 16 bits, so one armed transfer can count more than 512 samples across repeated fill and drain of the FIFO.
- R11: The control word at address 0 has bit 0 = transfer enable and bit 1 = error enable, and it reads back as written. Writes to address 3 set the 16-bit length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears error flags) |
| reg_addr | input | 2 | 0 control, 1 status, 2 arm, 3 length (write) / count (read) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the cycle `reg_rd` is high, otherwise 0 |
| push | input | 1 | Write a sample into the FIFO |
| push_data | input | 16 | Sample to write |
| pop | input | 1 | Remove the oldest sample |
| pop_data | output | 16 | Oldest sample in the FIFO |
| fifo_full | output | 1 | FIFO holds 512 samples |
| fifo_empty | output | 1 | FIFO holds no samples |

## Verification
The hardest state to reach from the ports is a push into a completely full FIFO, especially when it happens in the same cycle as a status read or an arm write. The stimulus reaches it by filling the FIFO with 512 directed pushes, which also passes the half-full threshold. It then presses extra pushes against the full FIFO, on their own, together with a status read, and together with an arm. Finally it drains the FIFO and compares every word, which shows that the rejected data never got in. A long armed transfer of 1000 samples and a seeded random phase then exercise counting across many fill levels.

// File: rtl/burst_fifo_pkg.sv
// Shared register addresses and status bit positions for the burst controller.
// Assumes a 2-bit register address space.
package burst_fifo_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ARM  = 2'd2,
        REG_LEN  = 2'd3
    } reg_addr_e;

    localparam int ST_DONE  = 0;
    localparam int ST_HALF  = 1;
    localparam int ST_OVR   = 2;
    localparam int ST_UND   = 3;
    localparam int ST_EMPTY = 4;
    localparam int ST_FULL  = 5;
    localparam int ST_ARMED = 6;
endpackage

// File: rtl/sample_fifo.sv
// Sample FIFO with a show-ahead read port.
// Rejects a push when full and a pop when empty, leaving state untouched.
// Assumes DEPTH is a power of two.
module sample_fifo #(
    parameter  int DEPTH = 512,
    parameter  int DW    = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level,
    output logic          push_ok,
    output logic          pop_ok
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full     = (level == LW'(DEPTH));
    assign empty    = (level == '0);
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    // Store an accepted sample at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R3
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(level) && $stable(wr_ptr)));

    // R3
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(level) && $stable(rd_ptr)));
endmodule

// File: rtl/sample_counter.sv
// Remaining-sample down-counter: loads on arm, subtracts moved samples,
// and saturates at zero until the next load.
module sample_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [CW-1:0] load_val,
    input  logic          step_en,
    input  logic [1:0]    moves,
    output logic [CW-1:0] count,
    output logic          at_zero
);
    assign at_zero = (count == '0);

    // Load on arm, otherwise count down with a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (arm) begin
            count <= load_val;
        end else if (step_en) begin
            if (count > CW'(moves)) count <= count - CW'(moves);
            else                    count <= '0;
        end
    end

    // R5
    count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !arm) |=> (count == '0));

    // R4
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == $past(load_val)));
endmodule

// File: rtl/status_flags.sv
// Sticky overrun/underrun flags. Setting is gated by the error enable.
// A status read clears them unless an error lands in the same cycle;
// an arm clears them unconditionally.
module status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic err_en,
    input  logic ovr_evt,
    input  logic und_evt,
    input  logic clr_read,
    input  logic clr_arm,
    output logic ovr,
    output logic und
);
    // Hold, clear or set each error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_arm) begin
            ovr <= 1'b0;
            und <= 1'b0;
        end else begin
            ovr <= (ovr && !clr_read) || (ovr_evt && err_en);
            und <= (und && !clr_read) || (und_evt && err_en);
        end
    end

    // R8
    ovr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(err_en));

    // R8
    und_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(und) |-> $past(err_en));

    // R9
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_arm |=> (!ovr && !und));
endmodule

// File: rtl/burst_fifo_ctrl.sv
// Counted FIFO burst transfer controller top.
// Decodes the register interface, holds the control, length and armed state,
// and combines the FIFO, counter and error flags into the status word.
// Assumes CW <= DW so that the count fits the read bus.
module burst_fifo_ctrl
    import burst_fifo_pkg::*;
#(
    parameter  int DEPTH = 512,
    parameter  int DW    = 16,
    parameter  int CW    = 16,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          fifo_full,
    output logic          fifo_empty
);
    logic          xfer_en, err_en, armed;
    logic [CW-1:0] len_reg;
    logic [CW-1:0] count;
    logic          at_zero;
    logic [LW-1:0] level;
    logic          push_ok, pop_ok;
    logic          ovr, und;
    logic          wr_ctrl, wr_arm, wr_len, rd_stat;
    logic [1:0]    moves;
    logic [DW-1:0] stat;

    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_arm  = reg_wr && (reg_addr == REG_ARM);
    assign wr_len  = reg_wr && (reg_addr == REG_LEN);
    assign rd_stat = reg_rd && (reg_addr == REG_STAT);
    assign moves   = 2'(push_ok) + 2'(pop_ok);

    // Control, length and armed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_en <= 1'b0;
            err_en  <= 1'b0;
            len_reg <= '0;
            armed   <= 1'b0;
        end else begin
            if (wr_ctrl) {err_en, xfer_en} <= reg_wdata[1:0];
            if (wr_len)  len_reg <= reg_wdata[CW-1:0];
            if (wr_arm)  armed <= 1'b1;
        end
    end

    sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .level     (level),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok)
    );

    sample_counter #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (wr_arm),
        .load_val (len_reg),
        .step_en  (armed && xfer_en),
        .moves    (moves),
        .count    (count),
        .at_zero  (at_zero)
    );

    status_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_en   (err_en),
        .ovr_evt  (push && fifo_full),
        .und_evt  (pop && fifo_empty),
        .clr_read (rd_stat),
        .clr_arm  (wr_arm),
        .ovr      (ovr),
        .und      (und)
    );

    // Assemble the status word.
    always_comb begin
        stat           = '0;
        stat[ST_DONE]  = xfer_en && armed && at_zero;
        stat[ST_HALF]  = xfer_en && (level >= LW'(DEPTH / 2));
        stat[ST_OVR]   = ovr;
        stat[ST_UND]   = und;
        stat[ST_EMPTY] = fifo_empty;
        stat[ST_FULL]  = fifo_full;
        stat[ST_ARMED] = armed;
    end

    // Read mux; the arm location reads as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                REG_CTRL: reg_rdata = DW'({err_en, xfer_en});
                REG_STAT: reg_rdata = stat;
                REG_LEN:  reg_rdata = DW'(count);
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R4
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: tb/test_burst_fifo_ctrl.sv
`timescale 1ns/1ps
module test_burst_fifo_ctrl;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        push = 1'b0, pop = 1'b0;
    logic [15:0] push_data = '0;
    logic [15:0] pop_data;
    logic        fifo_full, fifo_empty;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // Reference model state
    int q[$];
    bit m_en, m_err, m_armed, m_ovr, m_und;
    int m_len, m_cnt;

    always #2.5 clk = ~clk;

    burst_fifo_ctrl i_burst_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_status();
        int s = 0;
        if (m_en && m_armed && m_cnt == 0) s |= 1 << 0;
        if (m_en && q.size() >= DEPTH / 2) s |= 1 << 1;
        if (m_ovr) s |= 1 << 2;
        if (m_und) s |= 1 << 3;
        if (q.size() == 0) s |= 1 << 4;
        if (q.size() == DEPTH) s |= 1 << 5;
        if (m_armed) s |= 1 << 6;
        return s;
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            0: return {m_err, m_en};
            1: return exp_status();
            3: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // One clock cycle: drive, compare before the edge, update the model after it.
    task automatic cyc(input bit ps, input int pd, input bit pp, input bit w,
                       input bit r, input int a, input int wd, input string tag);
        bit full, empty, pok, qok, ovr_e, und_e, clr;
        int mv;
        @(negedge clk);
        push = ps; push_data = pd[15:0]; pop = pp;
        reg_wr = w; reg_rd = r; reg_addr = a[1:0]; reg_wdata = wd[15:0];
        #1;
        full = (q.size() == DEPTH); empty = (q.size() == 0);
        check(fifo_full == full && fifo_empty == empty, "R2", {fifo_full, fifo_empty}, {full, empty});
        if (!empty) check(pop_data == q[0][15:0], tag, pop_data, q[0]);
        if (r) check(reg_rdata == exp_read(a), tag, reg_rdata, exp_read(a));
        @(posedge clk);
        pok = ps && !full; qok = pp && !empty;
        ovr_e = ps && full && m_err; und_e = pp && empty && m_err;
        mv = int'(pok) + int'(qok);
        if (qok) void'(q.pop_front());
        if (pok) q.push_back(pd & 16'hFFFF);
        if (w && a == 2) begin
            m_ovr = 0; m_und = 0; m_cnt = m_len;
        end else begin
            clr = r && a == 1;
            m_ovr = (m_ovr && !clr) || ovr_e;
            m_und = (m_und && !clr) || und_e;
            if (m_armed && m_en) m_cnt = (m_cnt > mv) ? m_cnt - mv : 0;
        end
        if (w && a == 2) m_armed = 1;
        if (w && a == 0) begin m_en = wd[0]; m_err = wd[1]; end
        if (w && a == 3) m_len = wd & 16'hFFFF;
    endtask

    task automatic rd_reg(input int a, input string tag);
        cyc(0, 0, 0, 0, 1, a, 0, tag);
    endtask

    task automatic wr_reg(input int a, input int d);
        cyc(0, 0, 0, 1, 0, a, d, "R11");
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values; R4: arm location reads zero
        rd_reg(0, "R1"); rd_reg(1, "R1"); rd_reg(3, "R1"); rd_reg(2, "R4");

        // R11: control read-back
        wr_reg(0, 3); rd_reg(0, "R11");

        // R4/R5/R6: arm with junk data, short count, saturate at zero
        wr_reg(3, 5); wr_reg(2, 16'hBEEF); rd_reg(3, "R4"); rd_reg(1, "R4");
        for (int i = 0; i < 7; i++) cyc(1, 100 + i, 0, 0, 1, 3, 0, "R5");
        rd_reg(1, "R6");
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, 1, 3, 0, "R5");

        // R8/R9: underrun sets, read clears; gated by error enable
        cyc(0, 0, 1, 0, 0, 0, 0, "R8");
        rd_reg(1, "R8"); rd_reg(1, "R9");
        wr_reg(0, 1);
        cyc(0, 0, 1, 0, 0, 0, 0, "R8");
        rd_reg(1, "R8");
        wr_reg(0, 3);

        // R7/R2: fill to full, watching the half threshold
        for (int i = 0; i < DEPTH; i++) cyc(1, i * 3 + 1, 0, 0, 1, 1, 0, "R7");
        rd_reg(1, "R2");
        // R3/R8: overrun, then same-cycle read (set wins), then arm (arm wins)
        cyc(1, 16'hDEAD, 0, 0, 0, 0, 0, "R3");
        rd_reg(1, "R8");
        cyc(1, 16'hDEAD, 0, 0, 1, 1, 0, "R9");
        rd_reg(1, "R9");
        cyc(1, 16'hDEAD, 0, 1, 0, 2, 0, "R9");
        rd_reg(1, "R9");
        // R3: drain and compare, rejected words must be absent
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0, 0, 0, 0, "R3");
        rd_reg(1, "R3");

        // R10: one armed transfer longer than the FIFO
        wr_reg(3, 1000); wr_reg(2, 0);
        for (int i = 0; i < 1500; i++)
            cyc($urandom_range(0, 99) < 55, $urandom, $urandom_range(0, 99) < 50, 0, 1, 3, 0, "R10");
        rd_reg(1, "R10");

        // R5: random mix of traffic and register accesses
        for (int i = 0; i < 3000; i++) begin
            bit w = 0, r = 0;
            int a = 0, d = 0;
            if ($urandom_range(0, 99) < 12) begin
                a = $urandom_range(0, 3);
                if ($urandom_range(0, 1) == 1) begin
                    w = 1;
                    d = (a == 0) ? ($urandom_range(0, 9) < 8 ? 3 : $urandom_range(0, 3))
                                 : $urandom_range(0, 1023);
                end else r = 1;
            end
            cyc($urandom_range(0, 99) < 50, $urandom, $urandom_range(0, 99) < 48, w, r, a, d, "R5");
        end
        rd_reg(1, "R5"); rd_reg(3, "R5");

        finish_run();
    end
endmodule